// File: doc/BRIEF.md
# Unscaled-Offset Store Issue Unit

This unit sits between instruction decode and the memory write port of a 64-bit core. It takes one 32-bit instruction word per handshake, recognises the family of stores whose address offset is a signed 9-bit byte count that is never multiplied by the access size, and works out the access width and whether the source register is a general or a vector/floating-point register. The register indices it extracts are driven out at once, so that the register file can return the base value, the stack pointer and the store data in the same cycle the word is presented.

On acceptance the unit adds the sign-extended offset to the base and checks the result for alignment problems. It then either raises one write request on a 128-bit data bus with byte strobes, or reports a fault or an unrecognised word for one cycle. Base index 31 selects the stack pointer, which must itself be 16-byte aligned. Nothing else in the machine is changed by the store: no flags and no registers.

Only one operation is in flight at a time. A write request stays on the bus unchanged until the memory side takes it, and the next instruction word is accepted only after that.

Top module: `ustore_issue`

## Requirements
- R1: A word is in the family only if bits [29:27] are 111, bits [25:24] are 00, bit 21 is 0 and bits [11:10] are 00. Any word outside the family, or any combination not listed in R2, is reported by a one-cycle `unhandled` pulse in the cycle after acceptance and produces no write request and no fault.
- R2: The access width comes from size = bits [31:30], the vector bit = bit 26 and opc = bits [23:22]. With the vector bit 0 and opc 00, size 10 gives 4 bytes and size 11 gives 8 bytes. With the vector bit 1 and opc 00, size 00/01/10/11 gives 1/2/4/8 bytes. With the vector bit 1, opc 10 and size 00, the width is 16 bytes.
- R3: The write address is the 64-bit base plus the sign-extended offset in bits [20:12], wrapping modulo 2^64, and it is never scaled.
- R4: When the base index in bits [9:5] is 31, `sp_base` is used in place of `gpr_base`. If `sp_base[3:0]` is not zero, the result is a fault with code 1, and no write is issued.
- R5: When `strict_align` is 1 and the address is not a multiple of the access width, the result is a fault with code 2. The stack-pointer fault takes precedence.
- R6: When the low four address bits plus the access width exceed 16, so that the access would leave the 16-byte bus line, the result is a fault with code 3. This has the lowest precedence.
- R7: `wr_strb` has exactly width-many contiguous ones starting at byte lane `wr_addr[3:0]`. `wr_data` carries the low width bytes of `st_data` in those lanes, and zero in all other lanes.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr`, `wr_data` and `wr_strb` stay unchanged. The request completes on the first rising edge with `wr_ready` at 1.
- R9: `in_ready` is 1 only when no write, fault or unhandled report is pending and reset has been released for two clock edges. The outcome of an accepted word appears in the cycle after acceptance. Faults are reported by a one-cycle `fault_valid` pulse with `fault_code`, which reads 0 when no fault is reported.
- R10: `rn_idx` equals bits [9:5], `rt_idx` equals bits [4:0] and `rt_simd` equals bit 26 of the word currently on `in_insn`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can accept a word |
| in_insn | input | 32 | Instruction word |
| rn_idx | output | 5 | Base register index for operand lookup |
| rt_idx | output | 5 | Data register index for operand lookup |
| rt_simd | output | 1 | Data register is in the vector/floating-point file |
| gpr_base | input | 64 | Value of general register `rn_idx` |
| sp_base | input | 64 | Current stack pointer |
| st_data | input | 128 | Value of data register `rt_idx` in the selected file |
| strict_align | input | 1 | Enables data alignment faults |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 64 | Write byte address |
| wr_data | output | 128 | Write data placed in byte lanes |
| wr_strb | output | 16 | Byte-lane write enables |
| fault_valid | output | 1 | One-cycle fault report |
| fault_code | output | 2 | 1 stack pointer, 2 misaligned, 3 crosses bus line |
| unhandled | output | 1 | One-cycle report of an unrecognised word |

## Verification
The bench builds the unit with its default parameters: a 64-bit address, a 16-byte bus and a 16-byte stack-pointer alignment. With those values the 16-byte vector store fills the whole bus, so the bus-line crossing fault can be reached from every nonzero lane offset. The offset range around zero also reaches wrap-around of the full 64-bit address. A behavioural model predicts the outcome of every accepted word and is compared on every cycle while the write side stalls at random. The stimulus covers every width, both base sources, each fault precedence and words that fall outside the family.

// File: rtl/ustore_pkg.sv
`timescale 1ns/1ps
package ustore_pkg;

  localparam logic [4:0] SP_INDEX = 5'd31;

  typedef enum logic [1:0] {
    FLT_NONE          = 2'd0,
    FLT_SP_MISALIGN   = 2'd1,
    FLT_DATA_MISALIGN = 2'd2,
    FLT_LANE_SPAN     = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_REPORT = 2'd2
  } issue_state_e;

  typedef struct packed {
    logic       hit;
    logic [2:0] size_log2;
    logic [8:0] imm;
    logic [4:0] rn;
    logic [4:0] rt;
    logic       simd;
  } st_dec_t;

endpackage

// File: rtl/ustore_decode.sv
`timescale 1ns/1ps
module ustore_decode
  import ustore_pkg::*;
(
  input  logic [31:0] insn,
  output st_dec_t     dec
);

  logic       frame_ok;
  logic [1:0] sz;
  logic [1:0] opc;
  logic       vbit;

  always_comb begin
    sz    = insn[31:30];
    vbit  = insn[26];
    opc   = insn[23:22];
    // fixed bits that identify the unscaled store family (R1)
    frame_ok = (insn[29:27] == 3'b111) && (insn[25:24] == 2'b00) &&
               !insn[21] && (insn[11:10] == 2'b00);

    dec.hit       = 1'b0;
    dec.size_log2 = 3'd0;
    dec.imm       = insn[20:12];
    dec.rn        = insn[9:5];
    dec.rt        = insn[4:0];
    dec.simd      = vbit;

    // width selection (R2)
    if (frame_ok) begin
      if (!vbit) begin
        if ((opc == 2'b00) && sz[1]) begin
          dec.hit       = 1'b1;
          dec.size_log2 = {1'b0, sz};
        end
      end else if (opc == 2'b00) begin
        dec.hit       = 1'b1;
        dec.size_log2 = {1'b0, sz};
      end else if ((opc == 2'b10) && (sz == 2'b00)) begin
        dec.hit       = 1'b1;
        dec.size_log2 = 3'd4;
      end
    end
  end

endmodule

// File: rtl/ustore_agu.sv
`timescale 1ns/1ps
module ustore_agu
  import ustore_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int BUS_BYTES     = 16,
  parameter int SP_ALIGN_LOG2 = 4
) (
  input  logic [4:0]        rn,
  input  logic [8:0]        imm,
  input  logic [2:0]        size_log2,
  input  logic [ADDR_W-1:0] gpr_base,
  input  logic [ADDR_W-1:0] sp_base,
  input  logic              strict,
  output logic [ADDR_W-1:0] ea,
  output fault_e            fault
);

  localparam int LANE_W = $clog2(BUS_BYTES);

  logic [ADDR_W-1:0] base_sel;
  logic [ADDR_W-1:0] offset_ext;
  logic [LANE_W:0]   nbytes;
  logic [LANE_W:0]   span_end;
  logic [LANE_W-1:0] low_mask;
  logic              sp_bad;
  logic              mis;
  logic              span_bad;

  always_comb begin
    base_sel   = (rn == SP_INDEX) ? sp_base : gpr_base;
    offset_ext = {{(ADDR_W-9){imm[8]}}, imm};
    ea         = base_sel + offset_ext;

    nbytes   = (LANE_W+1)'(1) << size_log2;
    low_mask = nbytes[LANE_W-1:0] - LANE_W'(1);

    sp_bad   = (rn == SP_INDEX) && (|sp_base[SP_ALIGN_LOG2-1:0]);
    mis      = strict && (|(ea[LANE_W-1:0] & low_mask));
    span_end = {1'b0, ea[LANE_W-1:0]} + nbytes;
    span_bad = span_end > (LANE_W+1)'(BUS_BYTES);

    // precedence: stack pointer, strict alignment, bus line crossing
    if (sp_bad)        fault = FLT_SP_MISALIGN;
    else if (mis)      fault = FLT_DATA_MISALIGN;
    else if (span_bad) fault = FLT_LANE_SPAN;
    else               fault = FLT_NONE;
  end

endmodule

// File: rtl/ustore_lanes.sv
`timescale 1ns/1ps
module ustore_lanes #(
  parameter  int BUS_BYTES = 16,
  localparam int LANE_W    = $clog2(BUS_BYTES),
  localparam int DATA_W    = BUS_BYTES * 8
) (
  input  logic [2:0]           size_log2,
  input  logic [LANE_W-1:0]    lane_off,
  input  logic [DATA_W-1:0]    src,
  output logic [BUS_BYTES-1:0] strb,
  output logic [DATA_W-1:0]    data
);

  logic [LANE_W:0]   nbytes;
  logic [LANE_W:0]   lane_end;
  logic [DATA_W-1:0] src_masked;

  always_comb begin
    nbytes   = (LANE_W+1)'(1) << size_log2;
    lane_end = {1'b0, lane_off} + nbytes;
  end

  for (genvar b = 0; b < BUS_BYTES; b++) begin : g_lane
    assign src_masked[b*8 +: 8] = ((LANE_W+1)'(b) < nbytes) ? src[b*8 +: 8] : 8'h00;
    assign strb[b] = ({1'b0, lane_off} <= (LANE_W+1)'(b)) && ((LANE_W+1)'(b) < lane_end);
  end

  always_comb begin
    data = src_masked << {lane_off, 3'b000};
  end

endmodule

// File: rtl/ustore_issue.sv
`timescale 1ns/1ps
module ustore_issue
  import ustore_pkg::*;
#(
  parameter  int ADDR_W        = 64,
  parameter  int BUS_BYTES     = 16,
  parameter  int SP_ALIGN_LOG2 = 4,
  localparam int LANE_W        = $clog2(BUS_BYTES),
  localparam int DATA_W        = BUS_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [31:0]          in_insn,
  output logic [4:0]           rn_idx,
  output logic [4:0]           rt_idx,
  output logic                 rt_simd,
  input  logic [ADDR_W-1:0]    gpr_base,
  input  logic [ADDR_W-1:0]    sp_base,
  input  logic [DATA_W-1:0]    st_data,
  input  logic                 strict_align,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [DATA_W-1:0]    wr_data,
  output logic [BUS_BYTES-1:0] wr_strb,
  output logic                 fault_valid,
  output logic [1:0]           fault_code,
  output logic                 unhandled
);

  st_dec_t              dec;
  logic [ADDR_W-1:0]    ea;
  fault_e               agu_fault;
  logic [BUS_BYTES-1:0] lane_strb;
  logic [DATA_W-1:0]    lane_data;

  logic [1:0]           rst_pipe;
  logic                 rst_ok;

  issue_state_e         state_q, state_d;
  logic                 load_en;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    data_q;
  logic [BUS_BYTES-1:0] strb_q;
  fault_e               fault_q;
  logic                 unh_q;

  ustore_decode u_dec (
    .insn (in_insn),
    .dec  (dec)
  );

  ustore_agu #(
    .ADDR_W        (ADDR_W),
    .BUS_BYTES     (BUS_BYTES),
    .SP_ALIGN_LOG2 (SP_ALIGN_LOG2)
  ) u_agu (
    .rn        (dec.rn),
    .imm       (dec.imm),
    .size_log2 (dec.size_log2),
    .gpr_base  (gpr_base),
    .sp_base   (sp_base),
    .strict    (strict_align),
    .ea        (ea),
    .fault     (agu_fault)
  );

  ustore_lanes #(
    .BUS_BYTES (BUS_BYTES)
  ) u_lanes (
    .size_log2 (dec.size_log2),
    .lane_off  (ea[LANE_W-1:0]),
    .src       (st_data),
    .strb      (lane_strb),
    .data      (lane_data)
  );

  // operand lookup indices, straight from the presented word (R10)
  assign rn_idx  = dec.rn;
  assign rt_idx  = dec.rt;
  assign rt_simd = dec.simd;

  // reset release synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  // next state
  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (in_valid && rst_ok) begin
          load_en = 1'b1;
          state_d = (dec.hit && (agu_fault == FLT_NONE)) ? ST_ISSUE : ST_REPORT;
        end
      end
      ST_ISSUE:  if (wr_ready) state_d = ST_IDLE;
      ST_REPORT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      strb_q  <= '0;
      fault_q <= FLT_NONE;
      unh_q   <= 1'b0;
    end else if (load_en) begin
      addr_q  <= ea;
      data_q  <= lane_data;
      strb_q  <= lane_strb;
      fault_q <= dec.hit ? agu_fault : FLT_NONE;
      unh_q   <= !dec.hit;
    end
  end

  assign in_ready    = (state_q == ST_IDLE) && rst_ok;
  assign wr_valid    = (state_q == ST_ISSUE);
  assign wr_addr     = addr_q;
  assign wr_data     = data_q;
  assign wr_strb     = strb_q;
  assign fault_valid = (state_q == ST_REPORT) && (fault_q != FLT_NONE);
  assign fault_code  = fault_valid ? fault_q : FLT_NONE;
  assign unhandled   = (state_q == ST_REPORT) && unh_q;

  // request held until taken
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_strb)));

  // at most one outcome is reported at a time
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_valid, fault_valid, unhandled}));

  // no new word while an outcome is pending
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || fault_valid || unhandled) |-> !in_ready);

  // reports are single-cycle pulses
  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid || unhandled) |=> !(fault_valid || unhandled));

  // strobes are one nonempty contiguous run
  assert_strb_contig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_strb != '0) &&
      (((wr_strb + (wr_strb & (~wr_strb + BUS_BYTES'(1)))) & wr_strb) == '0)));

  // unrecognised words end in the unhandled report
  assert_unhandled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !dec.hit) |=> (unhandled && !wr_valid));

  // misaligned stack pointer base faults
  assert_sp_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && dec.hit && (rn_idx == SP_INDEX) &&
     (|sp_base[SP_ALIGN_LOG2-1:0])) |=> (fault_valid && (fault_code == 2'd1)));

endmodule

// File: tb/ustore_issue_test.sv
`timescale 1ns/1ps
module ustore_issue_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_insn = '0;
  logic [4:0]   rn_idx, rt_idx;
  logic         rt_simd;
  logic [63:0]  gpr_base = '0;
  logic [63:0]  sp_base = '0;
  logic [127:0] st_data = '0;
  logic         strict_align = 1'b0;
  logic         wr_valid;
  logic         wr_ready = 1'b1;
  logic [63:0]  wr_addr;
  logic [127:0] wr_data;
  logic [15:0]  wr_strb;
  logic         fault_valid;
  logic [1:0]   fault_code;
  logic         unhandled;

  always #2.5 clk = ~clk;

  ustore_issue #(
    .ADDR_W (64), .BUS_BYTES (16), .SP_ALIGN_LOG2 (4)
  ) uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_insn (in_insn), .rn_idx (rn_idx), .rt_idx (rt_idx), .rt_simd (rt_simd),
    .gpr_base (gpr_base), .sp_base (sp_base), .st_data (st_data),
    .strict_align (strict_align), .wr_valid (wr_valid), .wr_ready (wr_ready),
    .wr_addr (wr_addr), .wr_data (wr_data), .wr_strb (wr_strb),
    .fault_valid (fault_valid), .fault_code (fault_code), .unhandled (unhandled)
  );

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit chk_en  = 1'b0;
  bit rdy_random = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
    n_total++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [1:0] sz, input logic v,
      input logic [1:0] opc, input logic [8:0] imm, input logic [4:0] rn,
      input logic [4:0] rt);
    return {sz, 3'b111, v, 2'b00, opc, 1'b0, imm, 2'b00, rn, rt};
  endfunction

  // ---------------- behavioural reference model ----------------
  int           m_state = 0;   // 0 idle, 1 write pending, 2 report
  logic [63:0]  e_addr;
  logic [127:0] e_data;
  logic [15:0]  e_strb;
  int           e_code;
  bit           e_unh;
  int           e_bytes;
  bit           e_held;

  task automatic predict(input logic [31:0] w);
    int nb;
    bit ok;
    logic [63:0] a;
    int off;
    ok = (w[29:27] == 3'b111) && (w[25:24] == 2'b00) && !w[21] && (w[11:10] == 2'b00);
    nb = 0;
    if (ok) begin
      if (!w[26]) begin
        if (w[23:22] == 2'b00 && w[31:30] == 2'b10) nb = 4;
        else if (w[23:22] == 2'b00 && w[31:30] == 2'b11) nb = 8;
        else ok = 0;
      end else if (w[23:22] == 2'b00) nb = 1 << w[31:30];
      else if (w[23:22] == 2'b10 && w[31:30] == 2'b00) nb = 16;
      else ok = 0;
    end
    e_unh = !ok;
    e_code = 0;
    e_bytes = nb;
    a = ((w[9:5] == 5'd31) ? sp_base : gpr_base) + {{55{w[20]}}, w[20:12]};
    off = int'(a[3:0]);
    if (ok) begin
      if (w[9:5] == 5'd31 && sp_base[3:0] != 4'd0) e_code = 1;
      else if (strict_align && (off % nb) != 0)   e_code = 2;
      else if (off + nb > 16)                     e_code = 3;
    end
    e_addr = a;
    e_strb = '0;
    e_data = '0;
    for (int i = 0; i < 16; i++) begin
      if (i >= off && i < off + nb) begin
        e_strb[i] = 1'b1;
        e_data[i*8 +: 8] = st_data[(i-off)*8 +: 8];
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0;
      e_held = 0;
    end else begin
      e_held = 0;
      case (m_state)
        0: if (in_valid && chk_en) begin
             predict(in_insn);
             m_state = (!e_unh && e_code == 0) ? 1 : 2;
           end
        1: if (wr_ready) m_state = 0; else e_held = 1;
        default: m_state = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_en) begin
      string ftag;
      check("R9", "in_ready", in_ready, m_state == 0);
      check(e_held ? "R8" : "R9", "wr_valid", wr_valid, m_state == 1);
      check("R1", "unhandled", unhandled, m_state == 2 && e_unh);
      case (e_code)
        1: ftag = "R4";
        2: ftag = "R5";
        3: ftag = "R6";
        default: ftag = "R9";
      endcase
      check(ftag, "fault_valid", fault_valid, m_state == 2 && e_code != 0);
      check(ftag, "fault_code", fault_code,
            (m_state == 2 && !e_unh) ? e_code : 0);
      if (m_state == 1) begin
        check("R3", "wr_addr", wr_addr, e_addr);
        check("R7", "wr_strb", wr_strb, e_strb);
        check("R7", "wr_data", wr_data, e_data);
        check("R2", "strobe count", $countones(wr_strb), e_bytes);
        if (e_held) check("R8", "held wr_addr", wr_addr, e_addr);
      end
      check("R10", "rn_idx", rn_idx, in_insn[9:5]);
      check("R10", "rt_idx", rt_idx, in_insn[4:0]);
      check("R10", "rt_simd", rt_simd, in_insn[26]);
    end
  end

  always @(negedge clk) begin
    #1;
    wr_ready = rdy_random ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  task automatic send(input logic [31:0] w, input logic [63:0] gb,
                      input logic [63:0] sb, input logic [127:0] d, input logic s);
    @(negedge clk); #1;
    in_valid = 1'b1; in_insn = w; gpr_base = gb; sp_base = sb;
    st_data = d; strict_align = s;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk);
      if (in_ready) break;
    end
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] rand_word();
    logic [8:0] imm;
    logic [4:0] rn;
    logic [4:0] rt;
    imm = 9'($urandom);
    rn  = ($urandom_range(0, 3) == 0) ? 5'd31 : 5'($urandom_range(0, 30));
    rt  = 5'($urandom);
    case ($urandom_range(0, 8))
      0: return enc(2'b10, 1'b0, 2'b00, imm, rn, rt);
      1: return enc(2'b11, 1'b0, 2'b00, imm, rn, rt);
      2: return enc(2'b00, 1'b1, 2'b00, imm, rn, rt);
      3: return enc(2'b01, 1'b1, 2'b00, imm, rn, rt);
      4: return enc(2'b10, 1'b1, 2'b00, imm, rn, rt);
      5: return enc(2'b11, 1'b1, 2'b00, imm, rn, rt);
      6: return enc(2'b00, 1'b1, 2'b10, imm, rn, rt);
      7: return enc(2'($urandom), 1'($urandom), 2'($urandom), imm, rn, rt);
      default: return $urandom;
    endcase
  endfunction

  localparam logic [127:0] PAT = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;

  initial begin
    // reset state (R9)
    repeat (2) @(negedge clk);
    check("R9", "in_ready in reset", in_ready, 1'b0);
    check("R9", "wr_valid in reset", wr_valid, 1'b0);
    check("R9", "fault_valid in reset", fault_valid, 1'b0);
    check("R1", "unhandled in reset", unhandled, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_en = 1'b1;

    // widths and lane placement (R2 R3 R7)
    send(enc(2'b10, 1'b0, 2'b00, 9'h1F8, 5'd1, 5'd3), 64'h1000_0010, 0, PAT, 0);
    send(enc(2'b11, 1'b0, 2'b00, 9'd16,  5'd2, 5'd4), 64'h2000, 0, PAT, 0);
    send(enc(2'b00, 1'b1, 2'b00, 9'd5,   5'd3, 5'd0), 64'h3000, 0, PAT, 0);
    send(enc(2'b01, 1'b1, 2'b00, 9'h1FF, 5'd4, 5'd1), 64'h4004, 0, PAT, 0);
    send(enc(2'b10, 1'b1, 2'b00, 9'd0,   5'd5, 5'd2), 64'h500C, 0, PAT, 0);
    send(enc(2'b11, 1'b1, 2'b00, 9'd0,   5'd6, 5'd7), 64'h6008, 0, PAT, 1);
    send(enc(2'b00, 1'b1, 2'b10, 9'd0,   5'd7, 5'd8), 64'h7000, 0, PAT, 1);
    // 64-bit wrap (R3)
    send(enc(2'b00, 1'b1, 2'b00, 9'h1FF, 5'd8, 5'd9), 64'h0, 0, PAT, 0);
    // stack pointer base, aligned and not (R4)
    send(enc(2'b11, 1'b0, 2'b00, 9'h100, 5'd31, 5'd1), 64'hDEAD_BEEF, 64'h8000_0000, PAT, 0);
    send(enc(2'b10, 1'b0, 2'b00, 9'd0,   5'd31, 5'd1), 64'h0, 64'h8004, PAT, 0);
    // stack pointer fault outranks strict misalignment (R4 R5)
    send(enc(2'b10, 1'b0, 2'b00, 9'd1,   5'd31, 5'd1), 64'h0, 64'h8008, PAT, 1);
    // strict alignment (R5)
    send(enc(2'b01, 1'b1, 2'b00, 9'd1,   5'd2, 5'd1), 64'h100, 0, PAT, 1);
    // strict misaligned that also crosses: code 2 wins (R5 R6)
    send(enc(2'b10, 1'b0, 2'b00, 9'd14,  5'd2, 5'd1), 64'h100, 0, PAT, 1);
    // bus line crossing (R6)
    send(enc(2'b10, 1'b0, 2'b00, 9'd14,  5'd2, 5'd1), 64'h100, 0, PAT, 0);
    send(enc(2'b00, 1'b1, 2'b10, 9'd8,   5'd2, 5'd1), 64'h100, 0, PAT, 0);
    // words outside the family or listed forms (R1)
    send(enc(2'b00, 1'b0, 2'b00, 9'd0, 5'd1, 5'd1), 64'h100, 0, PAT, 0);
    send(enc(2'b10, 1'b0, 2'b01, 9'd0, 5'd1, 5'd1), 64'h100, 0, PAT, 0);
    send(enc(2'b10, 1'b0, 2'b00, 9'd0, 5'd1, 5'd1) | 32'h0020_0000, 64'h100, 0, PAT, 0);
    send(enc(2'b10, 1'b0, 2'b00, 9'd0, 5'd1, 5'd1) | 32'h0000_0400, 64'h100, 0, PAT, 0);
    send(enc(2'b01, 1'b1, 2'b10, 9'd0, 5'd1, 5'd1), 64'h100, 0, PAT, 0);
    send(32'h0, 64'h100, 0, PAT, 0);

    // random stimulus with write-side stalls (R8 and all others)
    rdy_random = 1'b1;
    for (int k = 0; k < 600; k++) begin
      logic [63:0] sb;
      sb = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 0) sb[3:0] = 4'd0;
      send(rand_word(), {$urandom, $urandom}, sb,
           {$urandom, $urandom, $urandom, $urandom}, 1'($urandom));
    end
    rdy_random = 1'b0;
    repeat (10) @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_total++;
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

endmodule